// File: doc/BRIEF.md
# Split-Word Sleep-Aware Counter Read Port

This block is the read side of a 52-bit microsecond counter that can drop into a low-power sleep state. A 32-bit bus reads the counter at two addresses. The low address returns bits 31:0. The high address returns the remaining 20 counter bits together with a BUSY flag. The counter, its sleep policy and the bus protocol are handled elsewhere. This port sees the live count, an active/asleep indication and one read strobe per address, and it returns registered read data.

Reading the low word takes a 52-bit snapshot. The high word that follows is taken from that snapshot, so the pair cannot tear when the low word wraps between the two reads. While the counter sleeps, the port reports the last value it observed while the counter was active. The asleep condition seen at the low read is latched and reported as BUSY on the next high read. This holds even if the counter wakes in between. Software therefore repeats low-then-high pairs until BUSY reads 0.

Top module: `sctr_read_port`

## Requirements
- R1: A low-word read issued while the counter is active returns bits 31:0 of the live count on `rd_data`, in the cycle after the strobe.
- R2: `rd_valid` is 1 exactly in the cycle after a cycle in which either strobe was high. In every other cycle `rd_valid` is 0 and `rd_data` is zero. Both are zero after reset.
- R3: A low-word read captures all 52 bits. The next high-word read returns bits 51:32 of that capture, not of the live count.
- R4: High-word layout: bits 19:0 hold counter bits 51:32, bit 20 is BUSY (1 = not trustworthy), and bits 31:21 read as zero.
- R5: While the counter is asleep, a low-word read returns the last value observed while active (zero if it has not been active since reset), and the live input is ignored.
- R6: A high-word read with no low-word read since the previous high-word read (or since reset) reports BUSY=1 with the stored snapshot bits.
- R7: A low-word read made while asleep makes the next high-word read report BUSY=1, even if the counter is active at the time of the high read.
- R8: A low-word read made while active makes the next high-word read report BUSY=0, whatever the activity state at the high read.
- R9: When both strobes are high in the same cycle, the access acts as a low-word read. It opens a new pair and returns the low word.
- R10: Once the counter is active, repeating a low-then-high pair yields BUSY=0 and the live value, ending a software retry loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_live | input | 52 | Live counter value |
| cnt_active | input | 1 | 1 when the counter is in its active state |
| rd_lo | input | 1 | Read strobe for the low-word address |
| rd_hi | input | 1 | Read strobe for the high-word address |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a strobe |

## Verification
Every result is due exactly one clock edge after its strobe. This covers `rd_valid`, the low word and the high word with its BUSY bit. The snapshot and the BUSY latch change on the strobe edge, so a high read placed in the next cycle already sees them. The stale-value register tracks the live count on every active edge, which means the value a sleeping read returns is the live input from the last active cycle. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. Vectors are ordered so that each expected value follows from earlier rows.

// File: rtl/sctr_pkg.sv
package sctr_pkg;

  // Which bus access is being served this cycle.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } rd_sel_e;

  // Strobe decode: a low strobe wins when both are raised together.
  function automatic rd_sel_e decode_sel(input logic lo, input logic hi);
    if (lo)      return SEL_LO;
    else if (hi) return SEL_HI;
    else         return SEL_NONE;
  endfunction

endpackage

// File: rtl/sctr_stale_hold.sv
// Keeps the last count seen while active and presents the value a read should see.
module sctr_stale_hold #(
  parameter int CNT_W = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] live_i,
  input  logic             active_i,
  output logic [CNT_W-1:0] view_o,
  output logic [CNT_W-1:0] held_o
);

  logic [CNT_W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_q <= '0;
    else if (active_i) held_q <= live_i;
  end

  // Asleep: the live bus is not trustworthy, so the stored copy is shown.
  always_comb view_o = active_i ? live_i : held_q;
  assign held_o = held_q;

endmodule

// File: rtl/sctr_pair_track.sv
// Snapshot for a low/high pair plus the BUSY carried from the low read.
module sctr_pair_track
  import sctr_pkg::*;
#(
  parameter int CNT_W = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rd_sel_e          sel_i,
  input  logic [CNT_W-1:0] view_i,
  input  logic             active_i,
  output logic [CNT_W-1:0] snap_o,
  output logic             hi_busy_o
);

  logic [CNT_W-1:0] snap_q;
  logic             lo_stale_q;  // low read of the open pair saw sleep
  logic             open_q;      // a low read is waiting for its high read

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q     <= '0;
      lo_stale_q <= 1'b0;
      open_q     <= 1'b0;
    end else begin
      unique case (sel_i)
        SEL_LO: begin
          snap_q     <= view_i;
          lo_stale_q <= !active_i;
          open_q     <= 1'b1;
        end
        SEL_HI: begin
          open_q     <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign snap_o    = snap_q;
  // High read is trusted only when a pair is open and its low read was live.
  assign hi_busy_o = lo_stale_q || !open_q;

endmodule

// File: rtl/sctr_word_out.sv
// Formats and registers the bus word.
module sctr_word_out
  import sctr_pkg::*;
#(
  parameter int CNT_W  = 52,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_sel_e           sel_i,
  input  logic [CNT_W-1:0]  view_i,
  input  logic [CNT_W-1:0]  snap_i,
  input  logic              busy_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o
);

  localparam int HI_CNT_W = CNT_W - WORD_W;
  localparam int BUSY_POS = HI_CNT_W;

  function automatic logic [WORD_W-1:0] lo_word(input logic [CNT_W-1:0] v);
    return v[WORD_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] hi_word(input logic [CNT_W-1:0] v, input logic busy);
    logic [WORD_W-1:0] w;
    w = '0;
    w[HI_CNT_W-1:0] = v[CNT_W-1:WORD_W];
    w[BUSY_POS]     = busy;
    return w;
  endfunction

  logic [WORD_W-1:0] nxt_data;

  always_comb begin
    unique case (sel_i)
      SEL_LO:  nxt_data = lo_word(view_i);
      SEL_HI:  nxt_data = hi_word(snap_i, busy_i);
      default: nxt_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      data_o  <= nxt_data;
      valid_o <= (sel_i != SEL_NONE);
    end
  end

endmodule

// File: rtl/sctr_read_port.sv
module sctr_read_port
  import sctr_pkg::*;
#(
  parameter int CNT_W  = 52,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_live,
  input  logic              cnt_active,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);

  // Named internal events, visible to the bound checker.
  rd_sel_e          rd_sel;
  logic             ev_lo_rd;
  logic             ev_hi_rd;
  logic [CNT_W-1:0] view_val;
  logic [CNT_W-1:0] held_val;
  logic [CNT_W-1:0] snap_val;
  logic             hi_busy;

  assign rd_sel   = decode_sel(rd_lo, rd_hi);
  assign ev_lo_rd = (rd_sel == SEL_LO);
  assign ev_hi_rd = (rd_sel == SEL_HI);

  sctr_stale_hold #(.CNT_W(CNT_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .live_i   (cnt_live),
    .active_i (cnt_active),
    .view_o   (view_val),
    .held_o   (held_val)
  );

  sctr_pair_track #(.CNT_W(CNT_W)) u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (rd_sel),
    .view_i    (view_val),
    .active_i  (cnt_active),
    .snap_o    (snap_val),
    .hi_busy_o (hi_busy)
  );

  sctr_word_out #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (rd_sel),
    .view_i  (view_val),
    .snap_i  (snap_val),
    .busy_i  (hi_busy),
    .data_o  (rd_data),
    .valid_o (rd_valid)
  );

endmodule

// File: rtl/sctr_read_port_chk.sv
module sctr_read_port_chk #(
  parameter int CNT_W  = 52,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  cnt_live,
  input logic              cnt_active,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [CNT_W-1:0]  held_val
);

  localparam int BUSY_POS = CNT_W - WORD_W;

  assert_lo_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && cnt_active |=> rd_data == $past(cnt_live[WORD_W-1:0]));

  assert_valid_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo || rd_hi) |=> rd_valid);

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_lo || rd_hi) |=> !rd_valid && rd_data == '0);

  assert_hi_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi && !rd_lo |=> rd_data[WORD_W-1:BUSY_POS+1] == '0);

  assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_active |=> $stable(held_val));

  assert_double_hi_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !rd_lo) ##1 (rd_hi && !rd_lo) |=> rd_data[BUSY_POS]);

  assert_stale_lo_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi && !cnt_active) ##1 (rd_hi && !rd_lo) |=> rd_data[BUSY_POS]);

  assert_live_lo_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi && cnt_active) ##1 (rd_hi && !rd_lo) |=> !rd_data[BUSY_POS]);

  assert_both_as_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && rd_hi && cnt_active |=> rd_data == $past(cnt_live[WORD_W-1:0]));

endmodule

bind sctr_read_port sctr_read_port_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_live   (cnt_live),
  .cnt_active (cnt_active),
  .rd_lo      (rd_lo),
  .rd_hi      (rd_hi),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .held_val   (held_val)
);

// File: tb/sctr_read_port_tb.sv
module sctr_read_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] cnt_live = '0;
  logic        cnt_active = 1'b0;
  logic        rd_lo = 1'b0;
  logic        rd_hi = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  sctr_read_port u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_live(cnt_live), .cnt_active(cnt_active),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct packed {
    logic [51:0] live;
    logic        act;
    logic        lo;
    logic        hi;
    logic        vld;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  // High word: bits 19:0 counter 51:32, bit 20 BUSY, rest zero (R4).
  localparam vec_t VEC [NV] = '{
    '{52'hABCDE_12345678, 1'b1, 1'b1, 1'b0, 1'b1, 32'h12345678, 8'd1},  // R1 live low
    '{52'hABCDF_00000000, 1'b1, 1'b0, 1'b1, 1'b1, 32'h000ABCDE, 8'd3},  // R3 snapshot, not live
    '{52'h00011_11111111, 1'b1, 1'b0, 1'b1, 1'b1, 32'h001ABCDE, 8'd6},  // R6 second high
    '{52'hFFFFF_FFFFFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 32'h11111111, 8'd5},  // R5 stale low
    '{52'h22222_22222222, 1'b1, 1'b0, 1'b1, 1'b1, 32'h00100011, 8'd7},  // R7 woke, still busy
    '{52'h33333_44444444, 1'b1, 1'b1, 1'b0, 1'b1, 32'h44444444, 8'd1},  // R1
    '{52'h99999_99999999, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00033333, 8'd8},  // R8 asleep at high
    '{52'h00000_00000000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000000, 8'd2},  // R2 idle
    '{52'h55555_66666666, 1'b1, 1'b1, 1'b1, 1'b1, 32'h66666666, 8'd9},  // R9 both strobes
    '{52'h00000_00000000, 1'b1, 1'b0, 1'b1, 1'b1, 32'h00055555, 8'd9},  // R9 pair opened
    '{52'h77777_77777777, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000000, 8'd2},  // R2 idle asleep
    '{52'h88888_88888888, 1'b0, 1'b1, 1'b0, 1'b1, 32'h00000000, 8'd5},  // R5 live ignored
    '{52'h12121_21212121, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00100000, 8'd7}   // R7
  };

  task automatic check(input int req, input logic [31:0] got_d, input logic [31:0] exp_d,
                       input logic got_v, input logic exp_v);
    checks++;
    if (got_d !== exp_d || got_v !== exp_v) begin
      failures++;
      $display("FAIL R%0d: data=%h valid=%b expected data=%h valid=%b",
               req, got_d, got_v, exp_d, exp_v);
    end
  endtask

  task automatic drive(input logic [51:0] live, input logic act, input logic lo, input logic hi);
    cnt_live = live; cnt_active = act; rd_lo = lo; rd_hi = hi;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R2: reset state
    check(2, rd_data, 32'h0, rd_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: high read straight after reset reports BUSY over a zero snapshot
    drive(52'hAAAAA_AAAAAAAA, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check(6, rd_data, 32'h00100000, rd_valid, 1'b1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].live, VEC[i].act, VEC[i].lo, VEC[i].hi);
      @(negedge clk);
      check(int'(VEC[i].req), rd_data, VEC[i].data, rd_valid, VEC[i].vld);
    end

    // R10: retry loop; asleep pair is busy, after waking a fresh pair is clean
    drive(52'h0BEEF_CAFE0001, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    drive(52'h0BEEF_CAFE0002, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check(10, {11'b0, rd_data[20], 20'b0}, 32'h00100000, rd_valid, 1'b1);
    drive(52'h0BEEF_CAFE0003, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check(10, rd_data, 32'hCAFE0003, rd_valid, 1'b1);
    drive(52'h0BEF0_00000000, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check(10, rd_data, 32'h0000BEEF, rd_valid, 1'b1);  // R8 BUSY clear, R3 snapshot

    // R6: reset closes an open pair
    drive(52'h12345_6789ABCD, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    drive(52'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(2, rd_data, 32'h0, rd_valid, 1'b0);
    rst_n = 1'b1;
    drive(52'h0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check(6, rd_data, 32'h00100000, rd_valid, 1'b1);
    drive(52'h0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check(2, rd_data, 32'h0, rd_valid, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule